// File: doc/BRIEF.md
# Three-Phase Gate Command Conditioner

This block sits between a PWM source and the six gate-drive outputs of a three-phase bridge. Each phase receives a high-switch command and a low-switch command. The low-switch command is always active low. The high-switch command is active low by default, and a static polarity input makes it active high. Every command first passes through a glitch filter. A level only reaches the output stage after it has stayed unchanged for a parameterised number of clock cycles.

The filtered requests then go to a per-phase interlock and deadtime stage. If a phase receives both requests at once, neither switch is driven. A switch may only turn on after the opposite switch of its phase has been off for exactly `DEAD_CYC` clock cycles. Any switch turns off on the clock after its request goes away. All phases use the same deadtime logic, so their timing matches cycle for cycle. A global shutdown input, driven by the fault manager, forces all six outputs off on the next clock edge.

Top module: `tri_phase_gate_conditioner`

## Requirements
- R1: The low-switch command `lo_cmd_n[i]` is active low: a 0 requests the low switch of phase i, a 1 releases it.
- R2: With `hi_act_high`=0 a 0 on `hi_cmd[i]` requests the high switch; with `hi_act_high`=1 a 1 requests it.
- R3: A command level held for fewer than `FILT_CYC` consecutive rising clock edges has no effect on any output.
- R4: A command level held for `FILT_CYC` edges is accepted. An output that may respond without waiting for deadtime changes on the (`FILT_CYC`+1)-th edge after the input change.
- R5: When a phase hands over from one switch to the other, both outputs of that phase are off for exactly `DEAD_CYC` clock cycles. This holds in both directions.
- R6: `hi_gate[i]` and `lo_gate[i]` are never 1 in the same cycle.
- R7: When both filtered requests of a phase are active, both outputs of that phase are 0 from the next cycle on.
- R8: While `shutdown` is 1, all six outputs are 0 from the first edge after it rises. After release, outputs resume from their requests.
- R9: A hand-over applied to all phases at once produces the same output edge cycle in every phase.
- R10: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | NUM_PHASES | High-switch commands, polarity set by hi_act_high |
| lo_cmd_n | input | NUM_PHASES | Low-switch commands, active low |
| hi_act_high | input | 1 | 1 makes hi_cmd active high, 0 active low |
| shutdown | input | 1 | Global forced turn-off |
| hi_gate | output | NUM_PHASES | High-switch gate commands, 1 = on |
| lo_gate | output | NUM_PHASES | Low-switch gate commands, 1 = on |

## Verification
The embedded properties check the following on every cycle:
- the two outputs of a phase are never on together;
- shutdown and a double request clear both outputs by the next edge;
- a turn-on never directly follows the opposite output being on;
- a filtered level only moves once its counter has reached its limit.

Some behaviour can only be shown by the bench's scenarios:
- the exact deadtime length;
- the filter latency and the rejection of a pulse one cycle too short;
- both input polarities;
- the cycle-for-cycle matching of the three phases.

// File: rtl/gdc_pkg.sv
package gdc_pkg;

   typedef struct packed {
      logic hi;
      logic lo;
   } gate_pair_t;

   // a phase that asks for both switches gets neither
   function automatic gate_pair_t arbitrate(input logic hi_req, input logic lo_req);
      gate_pair_t r;
      r.hi = hi_req & ~lo_req;
      r.lo = lo_req & ~hi_req;
      return r;
   endfunction

endpackage

// File: rtl/pulse_filter.sv
module pulse_filter #(
   parameter int FILT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (FILT_CYC < 1) begin : g_bad_filt
      $error("pulse_filter: FILT_CYC must be at least 1");
   end

   if (FILT_CYC == 1) begin : g_reg_only
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= d;
      end
   end else begin : g_counted
      localparam int CW = $clog2(FILT_CYC);
      localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q   <= 1'b0;
            cnt <= '0;
         end else if (d == q) begin
            cnt <= '0;
         end else if (cnt == LAST) begin
            q   <= d;
            cnt <= '0;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end

      // R3
      filt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (q != $past(q)) |-> ($past(cnt) == LAST));
   end

endmodule

// File: rtl/phase_dead.sv
module phase_dead
   import gdc_pkg::*;
#(
   parameter int DEAD_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hi_req,
   input  logic lo_req,
   input  logic shutdown,
   output logic hi_on,
   output logic lo_on
);

   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("phase_dead: DEAD_CYC must be at least 1");
   end

   localparam int CW = $clog2(DEAD_CYC + 1);
   localparam logic [CW-1:0] SAT  = CW'(DEAD_CYC);
   localparam logic [CW-1:0] OPEN = CW'(DEAD_CYC - 1);

   gate_pair_t    want;
   logic [CW-1:0] off_cnt;
   logic          gap_ok;
   logic          hi_d, lo_d;

   always_comb begin
      want   = arbitrate(hi_req, lo_req);
      gap_ok = (off_cnt >= OPEN);
      hi_d   = !shutdown && want.hi && (hi_on || (!lo_on && gap_ok));
      lo_d   = !shutdown && want.lo && (lo_on || (!hi_on && gap_ok));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_on   <= 1'b0;
         lo_on   <= 1'b0;
         off_cnt <= '0;
      end else begin
         hi_on <= hi_d;
         lo_on <= lo_d;
         if (hi_on || lo_on)    off_cnt <= '0;
         else if (off_cnt != SAT) off_cnt <= off_cnt + CW'(1);
      end
   end

   // R6
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_on && lo_on));

   // R8
   shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |=> (!hi_on && !lo_on));

   // R7
   both_req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_req && lo_req) |=> (!hi_on && !lo_on));

   // R5
   hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_on) |-> !$past(lo_on));

   // R5
   lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_on) |-> !$past(hi_on));

endmodule

// File: rtl/tri_phase_gate_conditioner.sv
module tri_phase_gate_conditioner #(
   parameter int NUM_PHASES = 3,
   parameter int FILT_CYC   = 4,
   parameter int DEAD_CYC   = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PHASES-1:0] hi_cmd,
   input  logic [NUM_PHASES-1:0] lo_cmd_n,
   input  logic                  hi_act_high,
   input  logic                  shutdown,
   output logic [NUM_PHASES-1:0] hi_gate,
   output logic [NUM_PHASES-1:0] lo_gate
);

   if (NUM_PHASES < 1) begin : g_bad_phases
      $error("tri_phase_gate_conditioner: NUM_PHASES must be at least 1");
   end

   logic [NUM_PHASES-1:0] hi_raw, lo_raw;
   logic [NUM_PHASES-1:0] hi_flt, lo_flt;

   // polarity is folded in before filtering so both filters idle at 0
   always_comb begin
      hi_raw = hi_act_high ? hi_cmd : ~hi_cmd;
      lo_raw = ~lo_cmd_n;
   end

   for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
      pulse_filter #(.FILT_CYC(FILT_CYC)) u_hi_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (hi_raw[p]),
         .q     (hi_flt[p])
      );

      pulse_filter #(.FILT_CYC(FILT_CYC)) u_lo_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (lo_raw[p]),
         .q     (lo_flt[p])
      );

      phase_dead #(.DEAD_CYC(DEAD_CYC)) u_dead (
         .clk      (clk),
         .rst_n    (rst_n),
         .hi_req   (hi_flt[p]),
         .lo_req   (lo_flt[p]),
         .shutdown (shutdown),
         .hi_on    (hi_gate[p]),
         .lo_on    (lo_gate[p])
      );
   end

endmodule

// File: tb/tri_phase_gate_conditioner_tb.sv
module tri_phase_gate_conditioner_tb;

   localparam int NP   = 3;
   localparam int FILT = 4;
   localparam int DEAD = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] hi_cmd = '1;
   logic [NP-1:0] lo_cmd_n = '1;
   logic          hi_act_high = 1'b0;
   logic          shutdown = 1'b0;
   logic [NP-1:0] hi_gate, lo_gate;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   tri_phase_gate_conditioner #(.NUM_PHASES(NP), .FILT_CYC(FILT), .DEAD_CYC(DEAD)) u_dut (
      .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd_n(lo_cmd_n),
      .hi_act_high(hi_act_high), .shutdown(shutdown),
      .hi_gate(hi_gate), .lo_gate(lo_gate)
   );

   // {pol, hi_cmd, lo_cmd_n, exp_hi, exp_lo}
   localparam logic [12:0] VEC [8] = '{
      {1'b0, 3'b111, 3'b111, 3'b000, 3'b000},
      {1'b0, 3'b110, 3'b111, 3'b001, 3'b000},
      {1'b0, 3'b111, 3'b000, 3'b000, 3'b111},
      {1'b0, 3'b010, 3'b101, 3'b101, 3'b010},
      {1'b0, 3'b000, 3'b000, 3'b000, 3'b000},
      {1'b1, 3'b111, 3'b111, 3'b111, 3'b000},
      {1'b1, 3'b011, 3'b110, 3'b010, 3'b000},
      {1'b1, 3'b000, 3'b010, 3'b000, 3'b101}
   };

   task automatic check(input string req, input int got, input int exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // hand over every phase at once and time the edges
   task automatic handover(input logic to_low, input string tag);
      int fall_s [NP];
      int rise_s [NP];
      for (int p = 0; p < NP; p++) begin fall_s[p] = -1; rise_s[p] = -1; end
      @(negedge clk);
      hi_cmd   = to_low ? 3'b111 : 3'b000;
      lo_cmd_n = to_low ? 3'b000 : 3'b111;
      for (int s = 1; s <= 24; s++) begin
         @(negedge clk);
         for (int p = 0; p < NP; p++) begin
            if ((hi_gate[p] & lo_gate[p]) == 1'b1)
               check("R6 overlap during handover", 1, 0);
            if (to_low) begin
               if (fall_s[p] < 0 && !hi_gate[p]) fall_s[p] = s;
               if (rise_s[p] < 0 && lo_gate[p])  rise_s[p] = s;
            end else begin
               if (fall_s[p] < 0 && !lo_gate[p]) fall_s[p] = s;
               if (rise_s[p] < 0 && hi_gate[p])  rise_s[p] = s;
            end
         end
      end
      for (int p = 0; p < NP; p++) begin
         check({"R4 turn-off latency ", tag}, fall_s[p], FILT + 1);
         check({"R5 deadtime cycles ", tag}, rise_s[p] - fall_s[p], DEAD);
         check({"R9 phase match ", tag}, rise_s[p], rise_s[0]);
      end
   endtask

   initial begin
      #(200000 * 20);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R10 reset state
      repeat (3) @(negedge clk);
      check("R10 hi during reset", int'(hi_gate), 0);
      check("R10 lo during reset", int'(lo_gate), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 hi after reset", int'(hi_gate), 0);
      check("R10 lo after reset", int'(lo_gate), 0);

      // R1 R2 R7 vector walk
      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         hi_act_high = VEC[v][12];
         hi_cmd      = VEC[v][11:9];
         lo_cmd_n    = VEC[v][8:6];
         repeat (16) @(negedge clk);
         check($sformatf("R1/R2/R7 vector %0d hi", v), int'(hi_gate), int'(VEC[v][5:3]));
         check($sformatf("R1/R2/R7 vector %0d lo", v), int'(lo_gate), int'(VEC[v][2:0]));
      end

      // idle, polarity active low
      @(negedge clk);
      hi_act_high = 1'b0; hi_cmd = 3'b111; lo_cmd_n = 3'b111;
      repeat (12) @(negedge clk);

      // R3 pulse one cycle too short
      lo_cmd_n[0] = 1'b0;
      repeat (FILT - 1) @(negedge clk);
      lo_cmd_n[0] = 1'b1;
      begin
         int seen = 0;
         for (int s = 0; s < 12; s++) begin
            @(negedge clk);
            if (lo_gate[0] || hi_gate[0]) seen = 1;
         end
         check("R3 short low pulse rejected", seen, 0);
      end

      // R4 pulse of exactly FILT cycles
      lo_cmd_n[0] = 1'b0;
      repeat (FILT) @(negedge clk);
      lo_cmd_n[0] = 1'b1;
      begin
         int seen = 0;
         for (int s = 0; s < 12; s++) begin
            @(negedge clk);
            if (lo_gate[0]) seen = 1;
         end
         check("R4 full-length pulse accepted", seen, 1);
      end

      // R5 R9 hand-overs both directions
      @(negedge clk);
      hi_cmd = 3'b000; lo_cmd_n = 3'b111;
      repeat (16) @(negedge clk);
      handover(1'b1, "hi to lo");
      handover(1'b0, "lo to hi");

      // R8 shutdown
      @(negedge clk);
      shutdown = 1'b1;
      @(negedge clk);
      check("R8 hi off one edge after shutdown", int'(hi_gate), 0);
      check("R8 lo off one edge after shutdown", int'(lo_gate), 0);
      repeat (6) @(negedge clk);
      check("R8 hi held off", int'(hi_gate), 0);
      @(negedge clk);
      shutdown = 1'b0;
      repeat (10) @(negedge clk);
      check("R8 hi resumes after release", int'(hi_gate), 7);

      finish_run();
   end

endmodule